// File: doc/BRIEF.md
# PCI Target Window Address Translator

This block sits behind the target side of a PCI interface and decides, for each inbound address, whether it falls into one of two programmable memory windows. A window that claims the address replaces the upper address bits with its own local-bus base, so PCI memory space and local-bus space may sit at different addresses. Windows are numbered 1 and 2. Index 0 is reserved and never reported as a hit.

Each window has three registers, written through a simple write port. The base register places the window in PCI memory space. The local register places it in local-bus space. The size/attribute register holds an enable bit, a prefetchable bit and the log2 of the size. A size of 2^n covers n from 12 (4 KB) to 32 (4 GB). Both bases are treated as aligned to the size, and any base bits below the size are ignored.

A small state machine holds the result of the last decode. It has three states. `ST_IDLE` means no request was sampled. `ST_HIT` means a memory command was claimed by a window. `ST_MISS` means a request was sampled but no window claimed it. On every clock edge the next state is chosen from the current request alone. No request leads to `ST_IDLE`. A memory command that an enabled window claims leads to `ST_HIT`. Any other request leads to `ST_MISS`. All outputs are derived from the state and the captured result.

Top module: `pci_tgt_xlate`

## Requirements
- R1: After reset, all response outputs are 0 and both windows are disabled. A memory request made right after reset therefore misses.
- R2: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was sampled high. With no request, every response output is 0.
- R3: Window w (1 or 2) hits when it is enabled and the request address equals its base in every bit at or above its size. `rsp_win` then reports w and is never 0 on a hit.
- R4: On a hit, `rsp_addr` takes the bits at or above the window size from the local base, and the bits below the size from the request address.
- R5: The size field is bits [13:8] of the size/attribute register and holds log2 of the size. Values below 12 act as 12 and values above 32 act as 32 (the whole space). The low 12 address bits always pass through unchanged.
- R6: Bit 0 of the size/attribute register is the enable. A window whose enable is 0 never hits.
- R7: Bit 1 of the size/attribute register is the prefetchable flag. On a hit, `rsp_pref` reports this flag for the window that hit.
- R8: When both windows match, window 1 wins.
- R9: Only memory commands are translated: 0110, 0111, 1100, 1110 and 1111. Every other command, including configuration read 1010 and write 1011 and I/O 0010 and 0011, gives a miss.
- R10: On a miss, `rsp_hit`, `rsp_win`, `rsp_addr` and `rsp_pref` are all 0.
- R11: `cfg_win` selects window 1 or 2. `cfg_sel` selects the register: 0 is the PCI base, 1 is the local base and 2 is size/attribute. A write with `cfg_win` of 0 or 3, or with `cfg_sel` of 3, changes nothing. A write applies to requests sampled at later edges.
- R12: Base bits below the window size, in either the PCI base or the local base, do not affect the hit decision or the translated address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 2 | Window number for the write (1 or 2) |
| cfg_sel | input | 2 | Register select: 0 PCI base, 1 local base, 2 size/attribute |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Request address and command are valid |
| req_addr | input | 32 | Inbound PCI address |
| req_cmd | input | 4 | PCI bus command |
| rsp_valid | output | 1 | A request was decoded in the previous cycle |
| rsp_hit | output | 1 | An enabled window claimed the request |
| rsp_win | output | 2 | Number of the window that hit, 0 on a miss |
| rsp_addr | output | 32 | Translated local-bus address, 0 on a miss |
| rsp_pref | output | 1 | Prefetchable flag of the window that hit |

## Verification
Single-window addresses are tried just inside and just past a window's upper edge. This separates a correct mask from one that is off by one bit. Overlapping windows are tried with both enabled and then with window 1 disabled, which shows that the priority order and the enable gate are two separate mechanisms. Size codes below 12 and above 32 test the clamp at each end. Bases written with nonzero low bits show that alignment comes from masking, not from the values software writes. A sweep over memory, configuration and I/O commands at an address that would otherwise hit isolates the command filter from the address match.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } dec_state_t;

    typedef enum logic [1:0] {
        SEL_PCI_BASE = 2'd0,
        SEL_LOC_BASE = 2'd1,
        SEL_SIZE_ATTR = 2'd2
    } reg_sel_t;

    localparam int ATTR_EN_BIT   = 0;
    localparam int ATTR_PREF_BIT = 1;
    localparam int SIZE_LSB      = 8;

    function automatic logic is_mem_cmd(input logic [3:0] cmd);
        return (cmd == 4'b0110) || (cmd == 4'b0111) || (cmd == 4'b1100) ||
               (cmd == 4'b1110) || (cmd == 4'b1111);
    endfunction

endpackage

// File: rtl/ptx_regbank.sv
module ptx_regbank #(
    parameter int ADDR_W  = 32,
    parameter int NUM_WIN = 2,
    parameter int LG_W    = 6,
    parameter int WIN_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WIN_W-1:0]  win,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] pci_base [NUM_WIN],
    output logic [ADDR_W-1:0] loc_base [NUM_WIN],
    output logic [LG_W-1:0]   size_lg  [NUM_WIN],
    output logic              enable   [NUM_WIN],
    output logic              pref     [NUM_WIN]
);
    import ptx_pkg::*;

    // Window w+1 lives in slot w; number 0 is reserved.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [WIN_W-1:0] MY_NUM = WIN_W'(w + 1);
        logic hit_me;
        assign hit_me = we && (win == MY_NUM);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pci_base[w] <= '0;
                loc_base[w] <= '0;
                size_lg[w]  <= '0;
                enable[w]   <= 1'b0;
                pref[w]     <= 1'b0;
            end else if (hit_me) begin
                unique case (reg_sel_t'(sel))
                    SEL_PCI_BASE:  pci_base[w] <= wdata;
                    SEL_LOC_BASE:  loc_base[w] <= wdata;
                    SEL_SIZE_ATTR: begin
                        size_lg[w] <= wdata[SIZE_LSB +: LG_W];
                        enable[w]  <= wdata[ATTR_EN_BIT];
                        pref[w]    <= wdata[ATTR_PREF_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/ptx_window.sv
module ptx_window #(
    parameter int ADDR_W  = 32,
    parameter int LG_W    = 6,
    parameter int PAGE_LG = 12
) (
    input  logic [ADDR_W-1:0] pci_base,
    input  logic [ADDR_W-1:0] loc_base,
    input  logic [LG_W-1:0]   size_lg,
    input  logic              enable,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] xaddr
);
    logic [ADDR_W-1:0] keep_mask;

    // Clamp the size into [PAGE_LG, ADDR_W], then mark the bits the window decodes.
    always_comb begin
        int lg_i;
        lg_i = int'(size_lg);
        if (lg_i < PAGE_LG) lg_i = PAGE_LG;
        if (lg_i > ADDR_W)  lg_i = ADDR_W;
        for (int i = 0; i < ADDR_W; i++) begin
            keep_mask[i] = (i >= lg_i);
        end
    end

    assign hit   = enable && (((addr ^ pci_base) & keep_mask) == '0);
    assign xaddr = (loc_base & keep_mask) | (addr & ~keep_mask);

endmodule

// File: rtl/pci_tgt_xlate.sv
module pci_tgt_xlate #(
    parameter int ADDR_W  = 32,
    parameter int NUM_WIN = 2,
    parameter int PAGE_LG = 12,
    localparam int LG_W   = $clog2(ADDR_W + 1),
    localparam int WIN_W  = $clog2(NUM_WIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WIN_W-1:0]  cfg_win,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_cmd,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WIN_W-1:0]  rsp_win,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_pref
);
    import ptx_pkg::*;

    logic [ADDR_W-1:0] pci_base [NUM_WIN];
    logic [ADDR_W-1:0] loc_base [NUM_WIN];
    logic [LG_W-1:0]   size_lg  [NUM_WIN];
    logic              enable   [NUM_WIN];
    logic              pref     [NUM_WIN];
    logic              win_hit  [NUM_WIN];
    logic [ADDR_W-1:0] win_xa   [NUM_WIN];

    ptx_regbank #(
        .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .LG_W(LG_W), .WIN_W(WIN_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .win(cfg_win), .sel(cfg_sel),
        .wdata(cfg_wdata), .pci_base(pci_base), .loc_base(loc_base),
        .size_lg(size_lg), .enable(enable), .pref(pref)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_dec
        ptx_window #(
            .ADDR_W(ADDR_W), .LG_W(LG_W), .PAGE_LG(PAGE_LG)
        ) u_win (
            .pci_base(pci_base[w]), .loc_base(loc_base[w]), .size_lg(size_lg[w]),
            .enable(enable[w]), .addr(req_addr), .hit(win_hit[w]), .xaddr(win_xa[w])
        );
    end

    // Pick the lowest-numbered hitting window.
    logic              any_hit;
    logic [WIN_W-1:0]  pick_num;
    logic [ADDR_W-1:0] pick_addr;
    logic              pick_pref;

    always_comb begin
        any_hit   = 1'b0;
        pick_num  = '0;
        pick_addr = '0;
        pick_pref = 1'b0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (win_hit[w]) begin
                any_hit   = 1'b1;
                pick_num  = WIN_W'(w + 1);
                pick_addr = win_xa[w];
                pick_pref = pref[w];
            end
        end
    end

    dec_state_t state_q, state_d;
    logic [WIN_W-1:0]  win_q;
    logic [ADDR_W-1:0] addr_q;
    logic              pref_q;

    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            state_d = (is_mem_cmd(req_cmd) && any_hit) ? ST_HIT : ST_MISS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= '0;
            addr_q <= '0;
            pref_q <= 1'b0;
        end else begin
            win_q  <= pick_num;
            addr_q <= pick_addr;
            pref_q <= pick_pref;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_win   = '0;
        rsp_addr  = '0;
        rsp_pref  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MISS: rsp_valid = 1'b1;
            ST_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_win   = win_q;
                rsp_addr  = addr_q;
                rsp_pref  = pref_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ptx_chk.sv
module ptx_chk #(
    parameter int ADDR_W  = 32,
    parameter int WIN_W   = 2,
    parameter int PAGE_LG = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_cmd,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [WIN_W-1:0]  rsp_win,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_pref
);
    import ptx_pkg::*;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && rsp_addr == '0));

    assert_win_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_win != '0));

    assert_low_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_addr[PAGE_LG-1:0] == $past(req_addr[PAGE_LG-1:0])));

    assert_nonmem_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_mem_cmd(req_cmd)) |=> !rsp_hit);

    assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && rsp_win == '0 && !rsp_pref));

endmodule

bind pci_tgt_xlate ptx_chk #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .PAGE_LG(PAGE_LG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cmd(req_cmd), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_win(rsp_win), .rsp_addr(rsp_addr), .rsp_pref(rsp_pref)
);

// File: tb/tb_pci_tgt_xlate.sv
module tb_pci_tgt_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_win = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_cmd = '0;
    logic        rsp_valid, rsp_hit, rsp_pref;
    logic [1:0]  rsp_win;
    logic [31:0] rsp_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pci_tgt_xlate dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_cmd(req_cmd), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_addr(rsp_addr),
        .rsp_pref(rsp_pref)
    );

    function automatic logic [31:0] szattr(bit en, bit pf, int lg);
        return {18'b0, 6'(lg), 6'b0, pf, en};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] win, logic [1:0] sel, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = win; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one request and check the registered response a cycle later.
    task automatic probe(string req, logic [31:0] a, logic [3:0] c,
                         bit eh, logic [1:0] ew, logic [31:0] ea, bit ep);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_cmd = c;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, "valid", 32'(rsp_valid), 32'd1);
        check(req, "hit",   32'(rsp_hit),   32'(eh));
        check(req, "win",   32'(rsp_win),   32'(ew));
        check(req, "addr",  rsp_addr,       ea);
        check(req, "pref",  32'(rsp_pref),  32'(ep));
    endtask

    task automatic t_reset();
        check("R1", "valid after reset", 32'(rsp_valid), 32'd0);
        check("R1", "hit after reset",   32'(rsp_hit),   32'd0);
        check("R1", "addr after reset",  rsp_addr,       32'd0);
        probe("R1", 32'h0000_0000, 4'b0110, 1'b0, 2'd0, 32'd0, 1'b0);
    endtask

    task automatic t_basic();
        wr(2'd1, 2'd0, 32'h8000_0000);
        wr(2'd1, 2'd1, 32'h0010_0000);
        wr(2'd1, 2'd2, szattr(1'b1, 1'b0, 20));
        probe("R3_R4", 32'h8001_2345, 4'b0110, 1'b1, 2'd1, 32'h0011_2345, 1'b0);
        probe("R3", 32'h800F_FFFF, 4'b0111, 1'b1, 2'd1, 32'h001F_FFFF, 1'b0);
        probe("R3_R10", 32'h8010_0000, 4'b0110, 1'b0, 2'd0, 32'd0, 1'b0);
        wr(2'd2, 2'd0, 32'hC000_0000);
        wr(2'd2, 2'd1, 32'h4000_0000);
        wr(2'd2, 2'd2, szattr(1'b1, 1'b1, 12));
        probe("R7", 32'hC000_0ABC, 4'b0110, 1'b1, 2'd2, 32'h4000_0ABC, 1'b1);
        probe("R10", 32'hC000_1000, 4'b0110, 1'b0, 2'd0, 32'd0, 1'b0);
    endtask

    task automatic t_idle();
        probe("R2", 32'h8000_0040, 4'b0110, 1'b1, 2'd1, 32'h0010_0040, 1'b0);
        @(negedge clk);
        check("R2", "idle valid", 32'(rsp_valid), 32'd0);
        check("R2", "idle hit",   32'(rsp_hit),   32'd0);
        check("R2", "idle addr",  rsp_addr,       32'd0);
    endtask

    task automatic t_cmd();
        probe("R9 memrd", 32'h8000_0100, 4'b0110, 1'b1, 2'd1, 32'h0010_0100, 1'b0);
        probe("R9 memwr", 32'h8000_0100, 4'b0111, 1'b1, 2'd1, 32'h0010_0100, 1'b0);
        probe("R9 rdmul", 32'h8000_0100, 4'b1100, 1'b1, 2'd1, 32'h0010_0100, 1'b0);
        probe("R9 rdline", 32'h8000_0100, 4'b1110, 1'b1, 2'd1, 32'h0010_0100, 1'b0);
        probe("R9 wrinv", 32'h8000_0100, 4'b1111, 1'b1, 2'd1, 32'h0010_0100, 1'b0);
        probe("R9 cfgrd", 32'h8000_0100, 4'b1010, 1'b0, 2'd0, 32'd0, 1'b0);
        probe("R9 cfgwr", 32'h8000_0100, 4'b1011, 1'b0, 2'd0, 32'd0, 1'b0);
        probe("R9 iord", 32'h8000_0100, 4'b0010, 1'b0, 2'd0, 32'd0, 1'b0);
        probe("R9 iowr", 32'h8000_0100, 4'b0011, 1'b0, 2'd0, 32'd0, 1'b0);
    endtask

    task automatic t_ignored();
        wr(2'd0, 2'd0, 32'h0000_0000);
        wr(2'd3, 2'd0, 32'h0000_0000);
        wr(2'd1, 2'd3, 32'h0000_0000);
        probe("R11 ignored", 32'h8000_0200, 4'b0110, 1'b1, 2'd1, 32'h0010_0200, 1'b0);
        wr(2'd1, 2'd1, 32'h0050_0000);
        probe("R11 applied", 32'h8000_0200, 4'b0110, 1'b1, 2'd1, 32'h0050_0200, 1'b0);
    endtask

    task automatic t_priority();
        wr(2'd1, 2'd0, 32'h8000_0000);
        wr(2'd1, 2'd1, 32'h1000_0000);
        wr(2'd1, 2'd2, szattr(1'b1, 1'b0, 28));
        wr(2'd2, 2'd0, 32'h8000_0000);
        wr(2'd2, 2'd1, 32'h2000_0000);
        wr(2'd2, 2'd2, szattr(1'b1, 1'b1, 12));
        probe("R8", 32'h8000_0010, 4'b0110, 1'b1, 2'd1, 32'h1000_0010, 1'b0);
        wr(2'd1, 2'd2, szattr(1'b0, 1'b0, 28));
        probe("R6_R7", 32'h8000_0010, 4'b0110, 1'b1, 2'd2, 32'h2000_0010, 1'b1);
        wr(2'd2, 2'd2, szattr(1'b0, 1'b1, 12));
        probe("R6", 32'h8000_0010, 4'b0110, 1'b0, 2'd0, 32'd0, 1'b0);
    endtask

    task automatic t_clamp();
        wr(2'd2, 2'd0, 32'hC000_0000);
        wr(2'd2, 2'd1, 32'h4000_0000);
        wr(2'd2, 2'd2, szattr(1'b1, 1'b0, 3));
        probe("R5 low", 32'hC000_0FFF, 4'b0110, 1'b1, 2'd2, 32'h4000_0FFF, 1'b0);
        probe("R5 low edge", 32'hC000_1000, 4'b0110, 1'b0, 2'd0, 32'd0, 1'b0);
        wr(2'd2, 2'd2, szattr(1'b0, 1'b0, 12));
        wr(2'd1, 2'd1, 32'h7777_0000);
        wr(2'd1, 2'd2, szattr(1'b1, 1'b0, 40));
        probe("R5 high", 32'h1234_5678, 4'b0110, 1'b1, 2'd1, 32'h1234_5678, 1'b0);
    endtask

    task automatic t_align();
        wr(2'd1, 2'd0, 32'h9000_0ABC);
        wr(2'd1, 2'd1, 32'h3000_0FFF);
        wr(2'd1, 2'd2, szattr(1'b1, 1'b0, 12));
        probe("R12", 32'h9000_0123, 4'b0110, 1'b1, 2'd1, 32'h3000_0123, 1'b0);
        probe("R12 outside", 32'h9000_1123, 4'b0110, 1'b0, 2'd0, 32'd0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_idle();
        t_cmd();
        t_ignored();
        t_priority();
        t_clamp();
        t_align();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule